// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers a bank of external interrupt pins into sticky pending requests and tells the processor, through one readable vector register, which enabled request is the most urgent. Each pin is first brought into the clock domain and then watched for transitions. A per-pin configuration bit decides whether only a high-to-low transition counts, or whether any change of level counts. A detected transition sets that pin's pending bit. The bit stays set until software writes a one to it.

Pending bits that are also enabled in a mask register drive a single interrupt request line towards the CPU. Among the enabled pending pins, pin 0 has the highest priority. The vector register reports the code of the winning pin as a multiple of four, with code 0 meaning that nothing is pending. The code is placed in the most significant byte of the word. A byte read returns the code as an offset into a table of 4-byte branch entries. A half-word read returns the code shifted left by eight, which spaces handler routines 0x400 bytes apart.

A read of the vector is a multi-cycle access, framed by a read strobe that stays high for the whole access. The vector value is captured in the first cycle of the access and held until the strobe falls. A request that arrives during the read therefore cannot change the value being returned. Reading the vector never clears any pending bit.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the pending, edge-control and mask registers are all zero, `irqOut` is low and the vector code reads as 0. The synchronizer stages reset to the high level, so pins that sit high through reset raise no request.
- R2: When a pin's edge-control bit (bit n of register 1) is 1, a high-to-low transition on that pin sets its pending bit, and a low-to-high transition leaves it clear.
- R3: When a pin's edge-control bit is 0, any transition on that pin sets its pending bit. The bit becomes visible after the third rising clock edge that follows the pin change (two synchronizer stages plus one edge-detect stage).
- R4: Pending bits are sticky. Writing register 2 clears every bit written as 1 and leaves every bit written as 0 unchanged. A new edge in the same cycle as a clear wins.
- R5: The vector code is (n+1)*4 for the lowest-numbered pin n whose pending and mask bits are both 1, and 0 when there is no such pin. Its two least significant bits are therefore always zero.
- R6: Reading register 0 returns the code in bits [7:0] for a byte access (size 0), in bits [15:8] for a half-word access (size 1), and in bits [31:24] for a word access (size 2 or 3). All other bits are zero.
- R7: The vector value is captured in the first cycle of a read. It stays unchanged while `busRead` remains high, even if a higher-priority request becomes pending during the read.
- R8: Reading any register, including the vector register, leaves the pending bits unchanged.
- R9: `irqOut` is high exactly when at least one pin has both its pending bit and its mask bit (register 3) set.
- R10: Registers 1, 2 and 3 read back their 16 bits zero-extended: a byte read gives bits [7:0] and a half-word read gives bits [15:0]. Writes take effect only when `busRead` is low. `busRdata` is zero whenever `busRead` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| extPin | input | 16 | External interrupt pins, asynchronous |
| busAddr | input | 2 | Register select: 0 vector, 1 edge control, 2 pending, 3 mask |
| busSize | input | 2 | Read size: 0 byte, 1 half-word, 2 or 3 word |
| busRead | input | 1 | Read strobe, held high for the whole read access |
| busWrite | input | 1 | Single-cycle write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the registers and the bus inputs |
| irqOut | output | 1 | Interrupt request to the CPU |

## Verification
The bound checker watches several properties on every cycle:
- that pending requests do not drop without a write, seen at `irqOut`;
- that a vector read returns the same data in every cycle of one access;
- that each access size puts the code in its own byte lane, with the two low bits zero;
- that the read bus is quiet when nothing is being read.

The bench scenarios are what show the rest:
- the three-edge latency from pin to pending;
- rising edges being ignored when only falling edges are selected;
- priority between simultaneous pins;
- a higher-priority arrival being held off until the read ends;
- reads leaving pending bits in place.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    RG_VECTOR = 2'd0,
    RG_EDGE   = 2'd1,
    RG_PEND   = 2'd2,
    RG_MASK   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic     wrEdge;
    logic     wrPend;
    logic     wrMask;
    logic     snapLoad;
    logic     snapHold;
    logic     rdEn;
    regSel_e  rdSel;
    accSize_e rdSize;
  } ctlStrobe_t;

endpackage

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int NUM_REQ = 16,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_REQ-1:0] req,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  // Scan from the lowest priority upward so the lowest index is the last one written.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] busAddr,
  input  logic [1:0] busSize,
  input  logic       busRead,
  input  logic       busWrite,
  output ctlStrobe_t strobe
);

  logic    readActiveQ;
  regSel_e addrSel;
  logic    wrOk;

  // Marks the cycles after the first one of a read access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readActiveQ <= 1'b0;
    else        readActiveQ <= busRead;
  end

  assign addrSel = regSel_e'(busAddr);
  assign wrOk    = busWrite & ~busRead;

  always_comb begin
    strobe          = '0;
    strobe.wrEdge   = wrOk && (addrSel == RG_EDGE);
    strobe.wrPend   = wrOk && (addrSel == RG_PEND);
    strobe.wrMask   = wrOk && (addrSel == RG_MASK);
    strobe.snapLoad = busRead & ~readActiveQ;
    strobe.snapHold = busRead & readActiveQ;
    strobe.rdEn     = busRead;
    strobe.rdSel    = addrSel;
    strobe.rdSize   = accSize_e'(busSize);
  end

endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] extPin,
  input  logic [DATA_W-1:0]   busWdata,
  input  ctlStrobe_t          strobe,
  output logic [DATA_W-1:0]   busRdata,
  output logic                irqOut
);

  localparam int IDX_W  = $clog2(NUM_PINS + 1);
  localparam int CODE_W = 8;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] pinNow;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] edgeCtlQ;
  logic [NUM_PINS-1:0] pendQ;
  logic [NUM_PINS-1:0] maskQ;
  logic [NUM_PINS-1:0] clearBits;
  logic [NUM_PINS-1:0] liveReq;
  logic                prioFound;
  logic [IDX_W-1:0]    prioIdx;
  logic [CODE_W-1:0]   liveCode;
  logic [CODE_W-1:0]   snapQ;
  logic [CODE_W-1:0]   vecCode;
  logic [DATA_W-1:0]   regWord;
  logic [DATA_W-1:0]   vecWord;

  // Synchronizer chain; stages rest high so idle-high pins raise nothing at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ[0] <= '1;
    else        syncQ[0] <= extPin;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) syncQ[s] <= '1;
      else        syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevQ <= '1;
    else        prevQ <= pinNow;
  end

  // Falling edges always count; rising edges only for pins in any-edge mode.
  assign edgeHit = (prevQ & ~pinNow) | (~edgeCtlQ & ~prevQ & pinNow);

  assign clearBits = strobe.wrPend ? busWdata[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ    <= '0;
      edgeCtlQ <= '0;
      maskQ    <= '0;
    end else begin
      pendQ <= (pendQ & ~clearBits) | edgeHit;
      if (strobe.wrEdge) edgeCtlQ <= busWdata[NUM_PINS-1:0];
      if (strobe.wrMask) maskQ    <= busWdata[NUM_PINS-1:0];
    end
  end

  assign liveReq = pendQ & maskQ;
  assign irqOut  = |liveReq;

  irqv_prio #(
    .NUM_REQ (NUM_PINS),
    .IDX_W   (IDX_W)
  ) u_prio (
    .req   (liveReq),
    .found (prioFound),
    .idx   (prioIdx)
  );

  assign liveCode = prioFound ? CODE_W'({prioIdx + IDX_W'(1), 2'b00}) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              snapQ <= '0;
    else if (strobe.snapLoad) snapQ <= liveCode;
  end

  assign vecCode = strobe.snapHold ? snapQ : liveCode;

  always_comb begin
    unique case (strobe.rdSize)
      SZ_BYTE: vecWord = DATA_W'(vecCode);
      SZ_HALF: vecWord = DATA_W'(vecCode) << 8;
      default: vecWord = DATA_W'(vecCode) << (DATA_W - CODE_W);
    endcase
  end

  always_comb begin
    unique case (strobe.rdSel)
      RG_EDGE: regWord = DATA_W'(edgeCtlQ);
      RG_PEND: regWord = DATA_W'(pendQ);
      RG_MASK: regWord = DATA_W'(maskQ);
      default: regWord = '0;
    endcase
    if (strobe.rdSize == SZ_BYTE)      regWord = regWord & DATA_W'(8'hFF);
    else if (strobe.rdSize == SZ_HALF) regWord = regWord & DATA_W'(16'hFFFF);
  end

  always_comb begin
    if (!strobe.rdEn)                 busRdata = '0;
    else if (strobe.rdSel == RG_VECTOR) busRdata = vecWord;
    else                              busRdata = regWord;
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] extPin,
  input  logic [1:0]          busAddr,
  input  logic [1:0]          busSize,
  input  logic                busRead,
  input  logic                busWrite,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                irqOut
);

  ctlStrobe_t strobe;

  irqv_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busRead  (busRead),
    .busWrite (busWrite),
    .strobe   (strobe)
  );

  irqv_datapath #(
    .NUM_PINS    (NUM_PINS),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .extPin   (extPin),
    .busWdata (busWdata),
    .strobe   (strobe),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        busAddr,
  input logic [1:0]        busSize,
  input logic              busRead,
  input logic              busWrite,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut
);

  // R4 / R8: a raised request can only drop after a write cycle
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irqOut) && !$past(busWrite)) |-> irqOut);

  // R7: vector data is stable across one read access
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busRead && $past(busRead) && busAddr == 2'd0 && $stable(busAddr) && $stable(busSize))
      |-> $stable(busRdata));

  // R5 / R6: byte lane of a byte vector read, code aligned to four
  p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busRead && busAddr == 2'd0 && busSize == 2'd0)
      |-> (busRdata[1:0] == 2'b00 && busRdata[DATA_W-1:8] == '0));

  // R6: half-word vector read uses bits [15:8] only
  p_half_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busRead && busAddr == 2'd0 && busSize == 2'd1)
      |-> (busRdata[9:0] == '0 && busRdata[DATA_W-1:16] == '0));

  // R10: read bus quiet when idle
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busRead |-> busRdata == '0);

endmodule

bind irq_vector_ctrl irqv_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busAddr  (busAddr),
  .busSize  (busSize),
  .busRead  (busRead),
  .busWrite (busWrite),
  .busRdata (busRdata),
  .irqOut   (irqOut)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] extPin = 16'hFFFF;
  logic [1:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .extPin(extPin), .busAddr(busAddr), .busSize(busSize),
    .busRead(busRead), .busWrite(busWrite), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  // Reference model
  logic [15:0] hist [3];
  logic [15:0] mPend, mEdge, mMask;
  logic [7:0]  mSnap;
  bit          mActive;

  function automatic logic [7:0] liveCodeOf(logic [15:0] p, logic [15:0] m);
    for (int i = 0; i < 16; i++)
      if (p[i] && m[i]) return 8'((i + 1) * 4);
    return 8'd0;
  endfunction

  function automatic logic [31:0] expRdata();
    logic [7:0]  c;
    logic [31:0] v;
    if (!busRead) return 32'd0;
    if (busAddr == 2'd0) begin
      c = mActive ? mSnap : liveCodeOf(mPend, mMask);
      if (busSize == 2'd0)      return {24'd0, c};
      else if (busSize == 2'd1) return {16'd0, c, 8'd0};
      else                      return {c, 24'd0};
    end
    v = (busAddr == 2'd1) ? {16'd0, mEdge} : (busAddr == 2'd2) ? {16'd0, mPend} : {16'd0, mMask};
    if (busSize == 2'd0)      v = v & 32'hFF;
    else if (busSize == 2'd1) v = v & 32'hFFFF;
    return v;
  endfunction

  always @(posedge clk) begin
    logic [15:0] edges, clr;
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) hist[k] = 16'hFFFF;
      mPend = 0; mEdge = 0; mMask = 0; mSnap = 0; mActive = 0;
    end else begin
      edges = 0;
      for (int i = 0; i < 16; i++) begin
        if (hist[2][i] && !hist[1][i]) edges[i] = 1'b1;
        if (!hist[2][i] && hist[1][i] && !mEdge[i]) edges[i] = 1'b1;
      end
      clr = (busWrite && !busRead && busAddr == 2'd2) ? busWdata[15:0] : 16'd0;
      if (busRead && !mActive) mSnap = liveCodeOf(mPend, mMask);
      mActive = busRead;
      if (busWrite && !busRead && busAddr == 2'd1) mEdge = busWdata[15:0];
      if (busWrite && !busRead && busAddr == 2'd3) mMask = busWdata[15:0];
      mPend = (mPend & ~clr) | edges;
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = extPin;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (busRdata !== expRdata()) begin
        failures++;
        $display("FAIL %s busRdata act=%h exp=%h at %0t", curReq, busRdata, expRdata(), $time);
      end
      checks++;
      if (irqOut !== |(mPend & mMask)) begin
        failures++;
        $display("FAIL R9 irqOut act=%b exp=%b at %0t", irqOut, |(mPend & mMask), $time);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doWrite(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(posedge clk); #1;
    busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic doRead(logic [1:0] a, logic [1:0] sz, output logic [31:0] v);
    @(posedge clk); #1;
    busAddr = a; busSize = sz; busRead = 1'b1;
    @(negedge clk); v = busRdata;
    @(posedge clk); #1;
    busRead = 1'b0;
  endtask

  task automatic setPin(int n, logic lvl);
    @(posedge clk); #1;
    extPin[n] = lvl;
  endtask

  logic [31:0] rv, firstV, lastV;

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    curReq = "R1";
    chk("R1 irqOut", {31'd0, irqOut}, 32'd0);
    doRead(2'd0, 2'd2, rv); chk("R1 vector", rv, 32'd0);
    doRead(2'd2, 2'd2, rv); chk("R1 pending", rv, 32'd0);

    // R10 mask write and sized read-back
    curReq = "R10";
    doWrite(2'd3, 32'hFFFF_FFFF);
    doRead(2'd3, 2'd1, rv); chk("R10 mask half", rv, 32'h0000_FFFF);
    doRead(2'd3, 2'd0, rv); chk("R10 mask byte", rv, 32'h0000_00FF);

    // R3 any-edge: falling on pin 5
    curReq = "R3";
    setPin(5, 1'b0);
    tick(1);
    chk("R3 not yet pending", {31'd0, irqOut}, 32'd0);
    tick(3);
    doRead(2'd0, 2'd0, rv); chk("R3/R5 byte code pin5", rv, 32'd24);
    doWrite(2'd2, 32'h0000_0020);
    doRead(2'd2, 2'd2, rv); chk("R4 cleared", rv, 32'd0);
    setPin(5, 1'b1);   // rising edge counts in any-edge mode
    tick(4);
    doRead(2'd2, 2'd2, rv); chk("R3 rising sets", rv, 32'h0000_0020);
    // R4 writing zeros keeps bits
    curReq = "R4";
    doWrite(2'd2, 32'h0000_0000);
    doRead(2'd2, 2'd2, rv); chk("R4 zero write keeps", rv, 32'h0000_0020);
    doWrite(2'd2, 32'h0000_FFFF);

    // R2 falling-only on pin 7
    curReq = "R2";
    doWrite(2'd1, 32'h0000_0080);
    setPin(7, 1'b0);
    tick(4);
    doRead(2'd2, 2'd2, rv); chk("R2 fall sets", rv, 32'h0000_0080);
    doWrite(2'd2, 32'h0000_0080);
    setPin(7, 1'b1);
    tick(5);
    doRead(2'd2, 2'd2, rv); chk("R2 rise ignored", rv, 32'd0);

    // R5/R6 priority and lanes
    curReq = "R5";
    setPin(9, 1'b0);
    extPin[2] = 1'b0;
    tick(4);
    doRead(2'd0, 2'd0, rv); chk("R5 priority byte", rv, 32'd12);
    curReq = "R6";
    doRead(2'd0, 2'd1, rv); chk("R6 half", rv, 32'h0000_0C00);
    doRead(2'd0, 2'd2, rv); chk("R6 word", rv, 32'h0C00_0000);
    doRead(2'd0, 2'd3, rv); chk("R6 wide", rv, 32'h0C00_0000);
    doWrite(2'd2, 32'h0000_FFFF);
    setPin(9, 1'b1); extPin[2] = 1'b1;
    tick(5);
    doWrite(2'd2, 32'h0000_FFFF);

    // R7 frozen during read, R8 no clear
    curReq = "R7";
    setPin(10, 1'b0);
    tick(4);
    @(posedge clk); #1;
    busAddr = 2'd0; busSize = 2'd0; busRead = 1'b1;
    @(negedge clk); firstV = busRdata;
    @(posedge clk); #1;
    extPin[1] = 1'b0;
    tick(6);
    @(negedge clk); lastV = busRdata;
    @(posedge clk); #1;
    busRead = 1'b0;
    chk("R7 first", firstV, 32'd44);
    chk("R7 held", lastV, 32'd44);
    doRead(2'd0, 2'd0, rv); chk("R7 new read sees pin1", rv, 32'd8);
    curReq = "R8";
    doRead(2'd2, 2'd2, rv); chk("R8 read keeps pending", rv, 32'h0000_0402);

    // R9 mask gates irq and vector
    curReq = "R9";
    doWrite(2'd3, 32'h0000_0000);
    tick(1);
    chk("R9 irq masked", {31'd0, irqOut}, 32'd0);
    doRead(2'd0, 2'd2, rv); chk("R9 vector masked", rv, 32'd0);
    doWrite(2'd3, 32'h0000_0400);
    tick(1);
    chk("R9 irq on", {31'd0, irqOut}, 32'd1);
    doRead(2'd0, 2'd0, rv); chk("R9 only pin10", rv, 32'd44);

    tick(3);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule